// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block collects interrupt requests from up to fifteen device lines and presents a single interrupt line to the processor. The sixteen request inputs form two groups of eight. Inputs 0–7 make up the primary group. Inputs 8–15 make up the secondary group, and its combined request takes the place of primary input 2. Each input can be masked and can be set to edge or level triggering. Within each group, a lower index has higher priority. Because the secondary group sits at primary input 2, the overall order from highest to lowest is 0, 1, 8–15, 3–7.

The processor answers an asserted `int_out` with a one-cycle `inta` pulse. On the next cycle the block returns a vector number: the programmable base of the winning group plus the input's index inside that group. Acknowledge moves the winning request from pending to in service. A later `eoi` pulse retires the highest-priority interrupt that is in service. A request of higher priority than everything in service can interrupt a running handler. Requests of lower priority wait until the handlers above them have retired.

Top module: `intc_cascade`

## Requirements
- R1: After reset every input is masked and edge-triggered, nothing is pending or in service, and `int_out`, `vec_valid` and `vec_out` are all zero.
- R2: When an unmasked edge-mode input goes from low to high, `int_out` rises one clock later. A line that is held high after its interrupt has been acknowledged and retired raises no further request.
- R3: An unmasked level-mode input requests for as long as it is high. If it is still high after its in-service bit has been retired, it requests again.
- R4: When a mask bit is 1, that input cannot raise `int_out`. An edge that arrives while the input is masked is still held pending and asserts `int_out` as soon as the mask bit is cleared.
- R5: When several requests are pending together, successive acknowledge/end-of-interrupt rounds serve them in the order 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7.
- R6: In the cycle after an `inta` pulse, `vec_valid` is high for exactly one cycle. During that cycle `vec_out` holds the group base plus the input index within the group (0–7). A write with `cfg_addr`=2 loads the primary base from `cfg_wdata[7:0]` and the secondary base from `cfg_wdata[15:8]`.
- R7: While an interrupt is in service, a higher-priority request asserts `int_out`. A request of equal or lower priority keeps `int_out` low and stays pending.
- R8: Acknowledging a secondary input puts both that input and the cascade position in service. A secondary request of higher priority than the secondary input in service still asserts `int_out`. Primary inputs 3–7 are held off.
- R9: `eoi` clears the highest-priority in-service bit. When it clears the last secondary in-service bit, it also clears the cascade bit.
- R10: If `inta` arrives while no request qualifies (for example, a level line dropped just before acknowledge), the vector is the primary base plus 7 and no in-service bit changes.
- R11: `irq_in[2]` has no effect. The cascade position is driven only by the secondary group.
- R12: Configuration writes with `cfg_addr`=0 load the mask (bit i is input i, 1 means masked). Writes with `cfg_addr`=1 load the trigger mode (bit i is input i, 1 means level).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Request lines; bit 2 unused |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 mask, 1 trigger mode, 2 vector bases |
| cfg_wdata | input | 16 | Configuration write data |
| inta | input | 1 | Acknowledge pulse from the processor |
| eoi | input | 1 | End-of-interrupt pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector valid, one cycle after `inta` |
| vec_out | output | 8 | Vector number |

## Verification
The bench builds the block with its default parameters: the cascade at primary position 2 and reset bases of 0x00 and 0x08. It then programs the bases to 0x40 and 0x50, so every returned vector shows both its group and its index. With these values, a sequence of acknowledges reveals the full cascade order. Nested service within the secondary group is tested together with the release of the cascade bit. Spurious acknowledge is reached by dropping a level line in the same cycle as `inta`.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int GRP_N = 8;
  localparam int IDX_W = $clog2(GRP_N);
  localparam int VEC_W = 8;

  typedef logic [GRP_N-1:0] grp_vec_t;
  typedef logic [IDX_W-1:0] grp_idx_t;

  typedef enum logic [1:0] {
    CFG_MASK = 2'd0,
    CFG_TRIG = 2'd1,
    CFG_BASE = 2'd2
  } cfg_sel_e;

  // Index of the highest-priority (lowest numbered) set bit.
  function automatic grp_idx_t lowest_idx(grp_vec_t v);
    grp_idx_t r;
    r = '0;
    for (int i = GRP_N - 1; i >= 0; i--) begin
      if (v[i]) r = grp_idx_t'(i);
    end
    return r;
  endfunction

  // Requests that outrank every in-service bit; the nested position may
  // pass its own in-service bit so deeper levels can preempt.
  function automatic grp_vec_t eligible(grp_vec_t req, grp_vec_t isr,
                                        logic nest_en, grp_idx_t nest_idx);
    grp_vec_t res;
    logic blocked;
    res = '0;
    blocked = 1'b0;
    for (int i = 0; i < GRP_N; i++) begin
      if (!blocked) begin
        if (isr[i]) res[i] = req[i] & nest_en & (grp_idx_t'(i) == nest_idx);
        else        res[i] = req[i];
      end
      if (isr[i]) blocked = 1'b1;
    end
    return res;
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(logic [VEC_W-1:0] base, grp_idx_t idx);
    return base + {{(VEC_W-IDX_W){1'b0}}, idx};
  endfunction
endpackage

// File: rtl/intc_group.sv
module intc_group
  import intc_pkg::*;
#(
  parameter bit NEST_EN  = 1'b0,
  parameter int NEST_IDX = 0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  grp_vec_t line,
  input  grp_vec_t mask,
  input  grp_vec_t lvl,
  input  logic     ack_en,
  input  grp_idx_t ack_idx,
  input  logic     eoi_en,
  input  grp_idx_t eoi_idx,
  output logic     req_any,
  output grp_idx_t req_idx,
  output grp_vec_t isr,
  output grp_idx_t isr_top
);
  grp_vec_t prev_q, edge_q, rise, pend, elig, ack_oh, eoi_oh;

  assign rise    = line & ~prev_q & ~lvl;
  assign pend    = (lvl & line) | (~lvl & edge_q);
  assign elig    = eligible(pend & ~mask, isr, NEST_EN, grp_idx_t'(NEST_IDX));
  assign req_any = |elig;
  assign req_idx = lowest_idx(elig);
  assign isr_top = lowest_idx(isr);
  assign ack_oh  = ack_en ? (grp_vec_t'(1) << ack_idx) : '0;
  assign eoi_oh  = eoi_en ? (grp_vec_t'(1) << eoi_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      edge_q <= '0;
      isr    <= '0;
    end else begin
      prev_q <= line;
      edge_q <= (edge_q & ~ack_oh & ~lvl) | rise;
      isr    <= (isr & ~eoi_oh) | ack_oh;
    end
  end
endmodule

// File: rtl/intc_cascade.sv
module intc_cascade
  import intc_pkg::*;
#(
  parameter int               CASC_PIN     = 2,
  parameter logic [VEC_W-1:0] RST_BASE_PRI = 8'h00,
  parameter logic [VEC_W-1:0] RST_BASE_SEC = 8'h08
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*GRP_N-1:0]   irq_in,
  input  logic                 cfg_wr,
  input  logic [1:0]           cfg_addr,
  input  logic [2*GRP_N-1:0]   cfg_wdata,
  input  logic                 inta,
  input  logic                 eoi,
  output logic                 int_out,
  output logic                 vec_valid,
  output logic [VEC_W-1:0]     vec_out
);
  localparam grp_idx_t CASC = grp_idx_t'(CASC_PIN);
  localparam grp_idx_t SPUR = grp_idx_t'(GRP_N - 1);

  logic [2*GRP_N-1:0] mask_q, lvl_q;
  logic [VEC_W-1:0]   base_pri, base_sec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '1;
      lvl_q    <= '0;
      base_pri <= RST_BASE_PRI;
      base_sec <= RST_BASE_SEC;
    end else if (cfg_wr) begin
      case (cfg_sel_e'(cfg_addr))
        CFG_MASK: mask_q <= cfg_wdata;
        CFG_TRIG: lvl_q  <= cfg_wdata;
        CFG_BASE: begin
          base_pri <= cfg_wdata[VEC_W-1:0];
          base_sec <= cfg_wdata[2*VEC_W-1:VEC_W];
        end
        default: ;
      endcase
    end
  end

  // Named internal events used by the checker.
  logic     pri_req, sec_req, ack_pri, ack_sec, eoi_pri, eoi_sec, sec_last, isr_any;
  grp_idx_t pri_idx, sec_idx, pri_top, sec_top;
  grp_vec_t pri_line, pri_lvl, pri_isr, sec_isr;
  logic     unused_casc_pin;

  assign unused_casc_pin = irq_in[CASC_PIN];

  always_comb begin
    pri_line           = irq_in[GRP_N-1:0];
    pri_line[CASC_PIN] = sec_req;
    pri_lvl            = lvl_q[GRP_N-1:0];
    pri_lvl[CASC_PIN]  = 1'b1;
  end

  assign ack_pri  = inta & pri_req;
  assign ack_sec  = ack_pri & (pri_idx == CASC);
  assign isr_any  = |pri_isr;
  assign sec_last = (sec_isr & ~(grp_vec_t'(1) << sec_top)) == '0;
  assign eoi_sec  = eoi & isr_any & (pri_top == CASC);
  assign eoi_pri  = eoi & isr_any & ((pri_top != CASC) | sec_last);

  intc_group #(.NEST_EN(1'b1), .NEST_IDX(CASC_PIN)) u_pri (
    .clk, .rst_n,
    .line(pri_line), .mask(mask_q[GRP_N-1:0]), .lvl(pri_lvl),
    .ack_en(ack_pri), .ack_idx(pri_idx),
    .eoi_en(eoi_pri), .eoi_idx(pri_top),
    .req_any(pri_req), .req_idx(pri_idx),
    .isr(pri_isr), .isr_top(pri_top)
  );

  intc_group #(.NEST_EN(1'b0), .NEST_IDX(0)) u_sec (
    .clk, .rst_n,
    .line(irq_in[2*GRP_N-1:GRP_N]), .mask(mask_q[2*GRP_N-1:GRP_N]),
    .lvl(lvl_q[2*GRP_N-1:GRP_N]),
    .ack_en(ack_sec), .ack_idx(sec_idx),
    .eoi_en(eoi_sec), .eoi_idx(sec_top),
    .req_any(sec_req), .req_idx(sec_idx),
    .isr(sec_isr), .isr_top(sec_top)
  );

  assign int_out = pri_req;

  logic [VEC_W-1:0] sel_vec;
  always_comb begin
    if (!pri_req)             sel_vec = vec_of(base_pri, SPUR);
    else if (pri_idx == CASC) sel_vec = vec_of(base_sec, sec_idx);
    else                      sel_vec = vec_of(base_pri, pri_idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      vec_valid <= inta;
      if (inta) vec_out <= sel_vec;
    end
  end
endmodule

module intc_cascade_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        inta,
  input logic        eoi,
  input logic        int_out,
  input logic        vec_valid,
  input logic [7:0]  vec_out,
  input logic [15:0] mask_q,
  input logic [7:0]  base_pri,
  input logic [7:0]  pri_isr,
  input logic [7:0]  sec_isr
);
  assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !int_out);

  assert_vec_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inta |=> vec_valid);

  assert_vec_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !inta |=> !vec_valid);

  assert_ack_grows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_out && !eoi) |=>
      ($countones({pri_isr, sec_isr}) > $countones($past({pri_isr, sec_isr}))));

  assert_casc_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|sec_isr) == pri_isr[2]);

  assert_eoi_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !inta && (|{pri_isr, sec_isr})) |=>
      ($countones({pri_isr, sec_isr}) < $countones($past({pri_isr, sec_isr}))));

  assert_spur_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_out) |=> (vec_out == $past(base_pri) + 8'd7));

  assert_spur_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_out && !eoi) |=> ($stable(pri_isr) && $stable(sec_isr)));
endmodule

bind intc_cascade intc_cascade_chk u_chk (
  .clk(clk), .rst_n(rst_n), .inta(inta), .eoi(eoi), .int_out(int_out),
  .vec_valid(vec_valid), .vec_out(vec_out), .mask_q(mask_q),
  .base_pri(base_pri), .pri_isr(pri_isr), .sec_isr(sec_isr)
);

// File: tb/intc_cascade_bench.sv
module intc_cascade_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        inta = 1'b0;
  logic        eoi = 1'b0;
  logic        int_out, vec_valid;
  logic [7:0]  vec_out;
  int          checks = 0;
  int          errors = 0;

  localparam logic [7:0] BP = 8'h40;
  localparam logic [7:0] BS = 8'h50;

  always #5 clk = ~clk;

  intc_cascade u_intc_cascade (
    .clk, .rst_n, .irq_in, .cfg_wr, .cfg_addr, .cfg_wdata,
    .inta, .eoi, .int_out, .vec_valid, .vec_out
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(logic [1:0] a, logic [15:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_wr = 1'b0;
  endtask

  // Expected vector for device line n, from the base plus in-group index.
  function automatic logic [7:0] exp_vec(int n);
    return (n < 8) ? BP + 8'(n) : BS + 8'(n - 8);
  endfunction

  task automatic ack(string tag, logic [7:0] exp);
    inta = 1'b1;
    tick();
    inta = 1'b0;
    chk({tag, " vec_valid R6"}, 32'(vec_valid), 1);
    chk({tag, " vector"}, 32'(vec_out), 32'(exp));
    tick();
    chk({tag, " vec_valid single R6"}, 32'(vec_valid), 0);
  endtask

  task automatic end_irq();
    eoi = 1'b1;
    tick();
    eoi = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 int_out", 32'(int_out), 0);
    chk("R1 vec_valid", 32'(vec_valid), 0);
    chk("R1 vec_out", 32'(vec_out), 0);
  endtask

  task automatic t_mask();
    cfg_write(2'd2, {BS, BP});
    irq_in[5] = 1'b1; tick();
    irq_in[5] = 1'b0; tick(2);
    chk("R4 masked edge quiet", 32'(int_out), 0);
    cfg_write(2'd0, 16'hFFDF);
    chk("R4 R12 pending after unmask", 32'(int_out), 1);
    ack("R4", exp_vec(5));
    end_irq();
    chk("R4 retired", 32'(int_out), 0);
    cfg_write(2'd0, 16'h0000);
  endtask

  task automatic t_edge();
    irq_in[4] = 1'b1; tick();
    chk("R2 rise asserts", 32'(int_out), 1);
    ack("R2", exp_vec(4));
    chk("R2 in service quiet", 32'(int_out), 0);
    end_irq(); tick();
    chk("R2 held line no repeat", 32'(int_out), 0);
    irq_in[4] = 1'b0; tick();
  endtask

  task automatic t_pin2();
    irq_in[2] = 1'b1; tick(3);
    chk("R11 pin 2 ignored", 32'(int_out), 0);
    irq_in[2] = 1'b0; tick();
  endtask

  task automatic t_prio();
    int order[5] = '{1, 9, 12, 3, 7};
    irq_in[7] = 1'b1; irq_in[3] = 1'b1; irq_in[12] = 1'b1;
    irq_in[9] = 1'b1; irq_in[1] = 1'b1;
    tick();
    foreach (order[k]) begin
      chk("R5 pending", 32'(int_out), 1);
      ack("R5 order", exp_vec(order[k]));
      end_irq();
    end
    chk("R5 drained", 32'(int_out), 0);
    irq_in = '0; tick();
  endtask

  task automatic t_nest();
    irq_in[10] = 1'b1; tick();
    ack("R8 secondary", exp_vec(10));
    irq_in[10] = 1'b0;
    irq_in[12] = 1'b1; tick();
    chk("R7 lower secondary waits", 32'(int_out), 0);
    irq_in[3] = 1'b1; tick();
    chk("R8 primary below cascade waits", 32'(int_out), 0);
    irq_in[8] = 1'b1; tick();
    chk("R8 higher secondary preempts", 32'(int_out), 1);
    ack("R8 nested", exp_vec(8));
    irq_in[9] = 1'b1; tick();
    chk("R7 below 8 waits", 32'(int_out), 0);
    end_irq();
    chk("R9 eoi retires 8", 32'(int_out), 1);
    ack("R9", exp_vec(9));
    end_irq();
    chk("R9 10 still in service", 32'(int_out), 0);
    end_irq();
    chk("R9 cascade released", 32'(int_out), 1);
    ack("R9 secondary next", exp_vec(12));
    end_irq();
    chk("R9 cascade freed for 3", 32'(int_out), 1);
    ack("R9 primary", exp_vec(3));
    end_irq();
    chk("R9 all retired", 32'(int_out), 0);
    irq_in = '0; tick();
  endtask

  task automatic t_level();
    cfg_write(2'd1, 16'h0040);
    irq_in[6] = 1'b1; tick();
    chk("R3 level asserts", 32'(int_out), 1);
    ack("R3", exp_vec(6));
    chk("R3 in service quiet", 32'(int_out), 0);
    end_irq();
    chk("R3 still held requests", 32'(int_out), 1);
    ack("R3 again", exp_vec(6));
    end_irq();
    irq_in[6] = 1'b0; tick();
    chk("R3 released", 32'(int_out), 0);
  endtask

  task automatic t_spur();
    irq_in[6] = 1'b1; tick();
    chk("R10 level up", 32'(int_out), 1);
    irq_in[6] = 1'b0;
    ack("R10 spurious", BP + 8'd7);
    irq_in[7] = 1'b1; tick();
    chk("R10 no in-service set", 32'(int_out), 1);
    ack("R10 real 7", exp_vec(7));
    end_irq();
    chk("R10 done", 32'(int_out), 0);
    irq_in = '0; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_mask();
    t_edge();
    t_pin2();
    t_prio();
    t_nest();
    t_level();
    t_spur();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule